// File: doc/BRIEF.md
# Image Pixel Burst Packer

This block moves a camera frame from a pixel FIFO onto a system bus during readout. Software gives it the number of pixels in the frame, a destination base address and a conversion option, then pulses `start`. The block drains 16-bit pixels from a first-word-fall-through FIFO and turns them into bus write requests with a running destination address.

While more than one block of pixels is still owed, it waits for the FIFO's half-full flag. It then sends one block (512 pixels by default) as 32-bit writes, with two pixels packed into each word. The last 512 pixels or fewer go out one at a time as 16-bit writes. An optional mode flips each pixel from straight binary to two's complement. A count of finished blocks can be read at any time, and a one-cycle `done` marks the end of the frame.

Top module: `img_word_packer`

## Requirements
- R1: While idle, a `start` pulse captures `pix_total`, `base_addr` and `conv_en` and makes `busy` high. A `start` pulse while busy is ignored and does not change the frame in progress.
- R2: A packed block begins only once `fifo_half` (at least 512 pixels stored) has been seen. `fifo_rd` is never high while `fifo_empty` is high.
- R3: While more than 512 pixels remain at a block boundary, the next 512 pixels go out as 256 writes with `wr_wide`=1. Each write carries two successive pixels, the earlier one in bits 31:16 and the later one in bits 15:0.
- R4: Once 512 or fewer pixels remain, each remaining pixel goes out as its own write with `wr_wide`=0, the pixel in bits 15:0 and zeros in bits 31:16.
- R5: With conversion captured as 1, bit 15 of every pixel is inverted before it is written (0..65535 maps to -32768..32767). With conversion 0, pixels pass unchanged.
- R6: The first write goes to `base_addr` with its low 10 bits forced to zero. Each wide write advances the address by 4 and each narrow write advances it by 2.
- R7: `blocks_done` clears on an accepted `start`, goes up by one when the last word of each packed block is acknowledged, and can be read at any time.
- R8: `done` is high for exactly one cycle, on the second clock edge after the edge that accepts the final write. With `pix_total`=0 it rises on the second edge after `start`. After `done`, `busy` is low.
- R9: `wr_req` stays high with stable `wr_addr`, `wr_data` and `wr_wide` until `wr_ack` is sampled high. The write is accepted on that edge.
- R10: After reset, `busy`, `done`, `wr_req` and `fifo_rd` are low and `blocks_done` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a frame (taken only when idle) |
| pix_total | input | 24 | Pixels in the frame |
| base_addr | input | 32 | Destination base address (low 10 bits ignored) |
| conv_en | input | 1 | Convert pixels to two's complement |
| fifo_empty | input | 1 | FIFO holds no pixel |
| fifo_half | input | 1 | FIFO holds at least 512 pixels |
| fifo_data | input | 16 | Head pixel of the FIFO (first-word fall-through) |
| fifo_rd | output | 1 | Pop the head pixel at this edge |
| wr_req | output | 1 | Write request |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 32 | Write data |
| wr_wide | output | 1 | 1 = 32-bit write, 0 = 16-bit write in bits 15:0 |
| wr_ack | input | 1 | Write accepted at this edge |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| blocks_done | output | 15 | Finished 512-pixel blocks in this frame |

## Verification
Every bus transfer is judged on the cycle its acknowledge is driven, because `wr_req`, `wr_addr` and `wr_data` are held from the state register until the accepting edge. `blocks_done` is checked at that same moment. Its expected value is the number of blocks fully acknowledged before the current word. Pops are checked in the cycle `fifo_rd` is high, before the edge that consumes the pixel. At that point the FIFO fill level must be at least 512 whenever the pop opens a packed block. `done` is expected exactly two edges after the final accepting edge, and two edges after `start` for an empty frame. The cycle after `done` must show it low again with `busy` low.

// File: rtl/img_word_packer.sv
module img_word_packer #(
  parameter int PIX_W      = 16,
  parameter int BLOCK_PIX  = 512,
  parameter int CNT_W      = 24,
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [CNT_W-1:0]    pix_total,
  input  logic [ADDR_W-1:0]   base_addr,
  input  logic                conv_en,
  input  logic                fifo_empty,
  input  logic                fifo_half,
  input  logic [PIX_W-1:0]    fifo_data,
  output logic                fifo_rd,
  output logic                wr_req,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic [2*PIX_W-1:0]  wr_data,
  output logic                wr_wide,
  input  logic                wr_ack,
  output logic                busy,
  output logic                done,
  output logic [CNT_W-$clog2(BLOCK_PIX)-1:0] blocks_done
);

  localparam int BLK_CW = CNT_W - $clog2(BLOCK_PIX);
  localparam int LEFT_W = $clog2(BLOCK_PIX) + 1;
  localparam int WIDE_STEP = (2 * PIX_W) / 8;
  localparam int NARROW_STEP = PIX_W / 8;

  typedef enum logic [2:0] {S_IDLE, S_PLAN, S_GETA, S_GETB, S_WRITE, S_DONE} state_t;

  state_t              st;
  logic [CNT_W-1:0]    rem;
  logic [LEFT_W-1:0]   blk_left;
  logic [PIX_W-1:0]    hi, lo;
  logic [ADDR_W-1:0]   addr;
  logic                wide, conv;
  logic [BLK_CW-1:0]   blocks;
  logic [PIX_W-1:0]    pix_in;

  assign pix_in = fifo_data ^ {conv, {(PIX_W-1){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      rem      <= '0;
      blk_left <= '0;
      hi       <= '0;
      lo       <= '0;
      addr     <= '0;
      wide     <= 1'b0;
      conv     <= 1'b0;
      blocks   <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          rem    <= pix_total;
          addr   <= {base_addr[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
          conv   <= conv_en;
          blocks <= '0;
          st     <= S_PLAN;
        end
        S_PLAN: begin
          if (rem == '0) begin
            st <= S_DONE;
          end else if (rem > CNT_W'(BLOCK_PIX)) begin
            if (fifo_half) begin
              wide     <= 1'b1;
              blk_left <= LEFT_W'(BLOCK_PIX);
              st       <= S_GETA;
            end
          end else begin
            wide <= 1'b0;
            st   <= S_GETA;
          end
        end
        S_GETA: if (!fifo_empty) begin
          hi <= pix_in;
          st <= wide ? S_GETB : S_WRITE;
        end
        S_GETB: if (!fifo_empty) begin
          lo <= pix_in;
          st <= S_WRITE;
        end
        S_WRITE: if (wr_ack) begin
          if (wide) begin
            addr     <= addr + ADDR_W'(WIDE_STEP);
            rem      <= rem - CNT_W'(2);
            blk_left <= blk_left - LEFT_W'(2);
            if (blk_left == LEFT_W'(2)) begin
              blocks <= blocks + 1'b1;
              st     <= S_PLAN;
            end else begin
              st <= S_GETA;
            end
          end else begin
            addr <= addr + ADDR_W'(NARROW_STEP);
            rem  <= rem - CNT_W'(1);
            st   <= S_PLAN;
          end
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign fifo_rd     = (st == S_GETA || st == S_GETB) && !fifo_empty;
  assign wr_req      = (st == S_WRITE);
  assign wr_addr     = addr;
  assign wr_data     = wide ? {hi, lo} : {{PIX_W{1'b0}}, hi};
  assign wr_wide     = wide;
  assign busy        = (st != S_IDLE);
  assign done        = (st == S_DONE);
  assign blocks_done = blocks;

endmodule

// File: rtl/img_word_packer_chk.sv
module img_word_packer_chk #(
  parameter int PIX_W  = 16,
  parameter int ADDR_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fifo_empty,
  input logic               fifo_rd,
  input logic               wr_req,
  input logic               wr_ack,
  input logic               wr_wide,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [2*PIX_W-1:0] wr_data,
  input logic               busy,
  input logic               done
);

  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> !fifo_empty);

  assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data) && $stable(wr_wide)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_wide_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_wide) |-> (wr_addr[1:0] == 2'b00));

  assert_narrow_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_wide) |-> (wr_data[2*PIX_W-1:PIX_W] == '0));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!wr_req && !fifo_rd));

endmodule

bind img_word_packer img_word_packer_chk #(.PIX_W(PIX_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_rd(fifo_rd),
  .wr_req(wr_req), .wr_ack(wr_ack), .wr_wide(wr_wide), .wr_addr(wr_addr),
  .wr_data(wr_data), .busy(busy), .done(done)
);

// File: tb/img_word_packer_bench.sv
module img_word_packer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] pix_total = '0;
  logic [31:0] base_addr = '0;
  logic        conv_en = 1'b0;
  logic        fifo_empty, fifo_half, fifo_rd;
  logic [15:0] fifo_data;
  logic        wr_req, wr_wide, busy, done;
  logic        wr_ack = 1'b0;
  logic [31:0] wr_addr, wr_data;
  logic [14:0] blocks_done;

  int n_checks = 0;
  int n_fail   = 0;
  int wr_cnt   = 0;
  int rd_cnt   = 0;
  logic [31:0] salt = 32'h1234_5678;

  always #5 clk = ~clk;

  img_word_packer u_img_word_packer (
    .clk(clk), .rst_n(rst_n), .start(start), .pix_total(pix_total),
    .base_addr(base_addr), .conv_en(conv_en), .fifo_empty(fifo_empty),
    .fifo_half(fifo_half), .fifo_data(fifo_data), .fifo_rd(fifo_rd),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_wide(wr_wide),
    .wr_ack(wr_ack), .busy(busy), .done(done), .blocks_done(blocks_done)
  );

  function automatic logic [15:0] pix_fn(int k);
    logic [31:0] h;
    h = (k * 32'h9E37_79B1) ^ salt;
    case (k % 8)
      3: return 16'h8000;
      5: return 16'h7FFF;
      6: return 16'hFFFF;
      7: return 16'h0000;
      default: return h[31:16];
    endcase
  endfunction

  function automatic logic [15:0] cv(logic [15:0] p, logic c);
    return c ? (p ^ 16'h8000) : p;
  endfunction

  assign fifo_empty = (wr_cnt == rd_cnt);
  assign fifo_half  = (wr_cnt - rd_cnt) >= 512;
  assign fifo_data  = pix_fn(rd_cnt);

  always @(posedge clk) if (fifo_rd) rd_cnt <= rd_cnt + 1;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_case(int n, logic [31:0] base, logic c, int rate, int ack_rate, bit poke);
    int rd0, wr0, q, nb, writes, cyc, last_acc, done_cyc;
    logic [31:0] base_al, exp_d;
    logic exp_w;
    bit fin;
    nb = (n == 0) ? 0 : (n - 1) / 512;
    base_al = {base[31:10], 10'b0};
    @(negedge clk);
    rd0 = rd_cnt; wr0 = wr_cnt;
    pix_total = n[23:0]; base_addr = base; conv_en = c; start = 1'b1;
    q = 0; writes = 0; cyc = 0; last_acc = -10; done_cyc = -1; fin = 0;
    while (!fin) begin
      @(negedge clk);
      cyc++;
      start = 1'b0;
      if (cyc == 1) chk(busy, "R1", "busy after start", 64'(busy), 64'd1);
      if (poke && cyc == 40) begin
        pix_total = 24'd3; base_addr = 32'hFFFF_FC00; conv_en = ~c; start = 1'b1;
      end
      if (cyc > 20000) begin
        chk(0, "R8", "watchdog expired", 64'(cyc), 64'd0);
        fin = 1;
      end
      if (done) begin
        done_cyc = cyc;
        if (n == 0) chk(cyc == 2, "R8", "done cycle empty frame", 64'(cyc), 64'd2);
        else chk(cyc == last_acc + 2, "R8", "done cycle after last ack", 64'(cyc), 64'(last_acc + 2));
        chk(q == n, "R8", "pixels written at done", 64'(q), 64'(n));
        chk(writes == nb * 256 + (n - nb * 512), "R4", "write count", 64'(writes), 64'(nb * 256 + (n - nb * 512)));
        chk(blocks_done == 15'(nb), "R7", "blocks at done", 64'(blocks_done), 64'(nb));
        fin = 1;
      end
      if (fifo_rd) begin
        int p;
        p = rd_cnt - rd0;
        if (p % 512 == 0 && p < nb * 512)
          chk((wr_cnt - rd_cnt) >= 512, "R2", "fill at block start", 64'(wr_cnt - rd_cnt), 64'd512);
      end
      if (wr_req) begin
        wr_ack = ($urandom % 100) < ack_rate;
        if (wr_ack) begin
          exp_w = (q < nb * 512);
          if (exp_w) exp_d = {cv(pix_fn(rd0 + q), c), cv(pix_fn(rd0 + q + 1), c)};
          else       exp_d = {16'h0, cv(pix_fn(rd0 + q), c)};
          chk(wr_wide == exp_w, exp_w ? "R3" : "R4", "width", 64'(wr_wide), 64'(exp_w));
          chk(wr_data == exp_d, c ? "R5" : (exp_w ? "R3" : "R4"), "data", 64'(wr_data), 64'(exp_d));
          chk(wr_addr == base_al + 32'(2 * q), "R6", "address", 64'(wr_addr), 64'(base_al + 32'(2 * q)));
          chk(blocks_done == 15'((q < nb * 512 ? q : nb * 512) / 512), "R7", "running blocks",
              64'(blocks_done), 64'((q < nb * 512 ? q : nb * 512) / 512));
          q += exp_w ? 2 : 1;
          writes++;
          last_acc = cyc;
        end
      end else begin
        wr_ack = 1'b0;
      end
      if ((wr_cnt - wr0) < n && (wr_cnt - rd_cnt) < 1024 && ($urandom % 100) < rate)
        wr_cnt++;
    end
    @(negedge clk);
    wr_ack = 1'b0;
    chk(!done && !busy, "R8", "done and busy low after pulse", {62'd0, done, busy}, 64'd0);
    chk(!wr_req && !fifo_rd, "R1", "quiet when idle", {62'd0, wr_req, fifo_rd}, 64'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !wr_req && !fifo_rd, "R10", "reset outputs",
        {60'd0, busy, done, wr_req, fifo_rd}, 64'd0);
    chk(blocks_done == 0, "R10", "reset blocks", 64'(blocks_done), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    run_case(0,    32'h1000_0000, 1'b0, 100, 100, 0);
    run_case(1,    32'h2000_03FF, 1'b1, 100, 100, 0);
    run_case(512,  32'h3000_0400, 1'b0, 100, 70,  0);
    run_case(513,  32'h4000_0123, 1'b0, 20,  100, 1);
    run_case(1024, 32'h5000_0000, 1'b1, 90,  60,  0);
    run_case(1030, 32'h6000_0abc, 1'b0, 60,  40,  1);
    for (int i = 0; i < 2; i++) begin
      salt = $urandom;
      run_case(1 + ($urandom % 1600), $urandom, 1'($urandom % 2), 30 + ($urandom % 70), 30 + ($urandom % 70), 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule